// File: doc/BRIEF.md
# CSR Access Execution Unit

This unit carries out the six control-and-status-register access operations of a RISC-V style core. It works against a small local set of CSRs: two plain registers with per-bit writable masks, a retired-instruction counter, a read-only view of that counter, and a read-only identity word. The execute stage presents a decoded instruction word, the rs1 operand value and a retire strobe. One clock later the unit returns the rd writeback value with its write enable, an illegal-instruction flag, and two strobes that mark when a CSR read or a CSR write actually took place.

The core rule is that the read and the write are each gated by instruction fields, not by data. A swap whose destination is x0 performs no read. A set or clear whose source field is zero performs no write. That field is the rs1 index for the register forms and the 5-bit immediate for the immediate forms. A source register that holds zero but is not x0 still writes. The counter advances on the retire strobe. An access reads its value from before the current instruction is counted, and a software write in the same cycle takes the place of that cycle's increment.

Top module: `csr_exec_unit`

## Requirements
- R1: An access is recognised only when `valid` is high, bits 6:0 of `instr` equal 1110011 and funct3 (bits 14:12) is one of these: 001 swap, 010 set, 011 clear, 101 swap-immediate, 110 set-immediate, 111 clear-immediate. The CSR address is taken from bits 31:20. Any other word produces no read, no write, no writeback and no illegal flag.
- R2: A swap writes the operand to the CSR and returns the old value. When rd (bits 11:7) is zero, no read takes place: `csr_rd_fire` and `rd_we` stay low and `rd_data` is zero.
- R3: Set ORs the operand into the CSR and clear ANDs its inverse into it. Every write changes only the bits in the register's writable mask. The scratch register at 0x7C0 is fully writable. The control register at 0x7C1 has mask 0x00000F0F and resets to 0x00005000.
- R4: For set and clear, the write is suppressed when the source field (bits 19:15) is zero, whatever `rs1_val` holds. A nonzero source index with a zero value still writes and raises `csr_wr_fire`.
- R5: The immediate forms use the 5-bit source field, zero-extended, as the operand.
- R6: A write that is not suppressed, aimed at a read-only CSR (0xC02 counter view, 0xFC0 identity = 0x12340001), raises `illegal`. A suppressed write to a read-only CSR is a legal read.
- R7: An access to an unimplemented address raises `illegal`. An illegal access writes neither the CSR nor rd, and raises neither fire strobe.
- R8: The counter (0xB02, read-only view 0xC02) adds one per cycle with `retire` high and wraps from all ones to zero. A read returns its value before that cycle's increment.
- R9: A write to the counter in a cycle with `retire` high replaces the increment, so the next access reads exactly the written value.
- R10: All outputs are registered and appear one clock after the access. `rd_we` is raised only for a read with nonzero rd. A synchronous active-low reset clears the outputs, the counter and the plain registers to their reset values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| valid | input | 1 | Instruction word is valid this cycle |
| instr | input | 32 | Instruction word |
| rs1_val | input | XLEN | Value of source register rs1 |
| retire | input | 1 | An instruction retires this cycle |
| rd_we | output | 1 | Writeback enable for rd |
| rd_addr | output | 5 | Destination register index |
| rd_data | output | XLEN | Old CSR value, zero-extended |
| illegal | output | 1 | Illegal-instruction flag |
| csr_rd_fire | output | 1 | A CSR read took place |
| csr_wr_fire | output | 1 | A CSR write took place |

## Verification
Wrong internal state in this unit shows at the ports one clock after the access that exposes it. A lost mask bit or a bad merge shows in `rd_data` on the next read of the same CSR. A wrong suppression decision shows at once in the fire strobes, and later as a value that should not have changed. A counter that increments on top of a write, or reads back its post-increment value, is off by one on the very next read of 0xB02 or 0xC02. The directed counter tests place those reads directly after the retire cycles and writes involved.

// File: rtl/csr_exec_pkg.sv
// Shared types and constants of the CSR access execution unit.
// Assumes the standard 32-bit instruction layout of a RISC-V style core.
package csr_exec_pkg;

    localparam logic [6:0] OPC_SYSTEM = 7'b1110011;

    // Implemented CSR addresses.
    localparam logic [11:0] A_SCRATCH = 12'h7C0;
    localparam logic [11:0] A_CTRL    = 12'h7C1;
    localparam logic [11:0] A_CNT     = 12'hB02;
    localparam logic [11:0] A_CNT_RO  = 12'hC02;
    localparam logic [11:0] A_IDENT   = 12'hFC0;

    // Operation kind, equal to funct3[1:0].
    typedef enum logic [1:0] {
        K_NONE = 2'b00,
        K_SWAP = 2'b01,
        K_SET  = 2'b10,
        K_CLR  = 2'b11
    } csr_kind_e;

    typedef struct packed {
        logic        is_csr;
        csr_kind_e   kind;
        logic        is_imm;
        logic [4:0]  rd;
        logic [4:0]  src;
        logic [11:0] addr;
    } csr_dec_t;

endpackage

// File: rtl/csr_decode.sv
// Field decoder for CSR access instructions.
// Extracts address, operation kind and register fields. It also decides
// whether a read and a write are requested, based on field indices only.
// Assumes the instruction word has already been qualified as valid elsewhere.
module csr_decode
    import csr_exec_pkg::*;
(
    input  logic [31:0] instr,
    output csr_dec_t    dec,
    output logic        rd_req,
    output logic        wr_req
);

    // Split the instruction word into its fields.
    always_comb begin
        dec.addr   = instr[31:20];
        dec.src    = instr[19:15];
        dec.rd     = instr[11:7];
        dec.is_imm = instr[14];
        dec.kind   = csr_kind_e'(instr[13:12]);
        dec.is_csr = (instr[6:0] == OPC_SYSTEM) && (instr[13:12] != 2'b00);
    end

    // The read is skipped only for a swap into x0; the write only for set/clear with a zero source field.
    always_comb begin
        rd_req = (dec.kind != K_SWAP) || (dec.rd != 5'd0);
        wr_req = (dec.kind == K_SWAP) || (dec.src != 5'd0);
    end

endmodule

// File: rtl/csr_plain_reg.sv
// One plain CSR with a per-bit writable mask fixed at elaboration.
// Bits outside the mask keep their reset value for ever.
// Assumes wr_en is already qualified by address match and legality.
module csr_plain_reg #(
    parameter int          XLEN  = 32,
    parameter logic [XLEN-1:0] MASK  = '1,
    parameter logic [XLEN-1:0] RESET = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [XLEN-1:0] wr_val,
    output logic [XLEN-1:0] q
);

    // Store writable bits from wr_val and hold the rest.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= RESET;
        end else if (wr_en) begin
            q <= (q & ~MASK) | (wr_val & MASK);
        end
    end

endmodule

// File: rtl/csr_retire_counter.sv
// Retired-instruction counter, XLEN wide, wrapping on overflow.
// A software write in a cycle replaces that cycle's hardware increment.
// Assumes retire is a single-cycle strobe per retired instruction.
module csr_retire_counter #(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            retire,
    input  logic            wr_en,
    input  logic [XLEN-1:0] wr_val,
    output logic [XLEN-1:0] cnt
);

    // Write takes priority over the increment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (wr_en) begin
            cnt <= wr_val;
        end else if (retire) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/csr_exec_unit.sv
// CSR access execution unit: runs swap/set/clear (register and immediate forms)
// against a local CSR set. The set holds plain masked registers, a retired-
// instruction counter with a read-only view, and a read-only identity word.
// Results are registered one cycle after the access.
// Assumes no pipeline hazards and a single privilege level.
module csr_exec_unit
    import csr_exec_pkg::*;
#(
    parameter int              XLEN        = 32,
    parameter logic [XLEN-1:0] SCR_MASK    = '1,
    parameter logic [XLEN-1:0] CTRL_MASK   = XLEN'(32'h0000_0F0F),
    parameter logic [XLEN-1:0] CTRL_RESET  = XLEN'(32'h0000_5000),
    parameter logic [XLEN-1:0] IDENT_VALUE = XLEN'(32'h1234_0001)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            valid,
    input  logic [31:0]     instr,
    input  logic [XLEN-1:0] rs1_val,
    input  logic            retire,
    output logic            rd_we,
    output logic [4:0]      rd_addr,
    output logic [XLEN-1:0] rd_data,
    output logic            illegal,
    output logic            csr_rd_fire,
    output logic            csr_wr_fire
);

    localparam int N_PLAIN = 2;
    localparam logic [N_PLAIN-1:0][11:0]     PL_ADDR  = {A_CTRL, A_SCRATCH};
    localparam logic [N_PLAIN-1:0][XLEN-1:0] PL_MASK  = {CTRL_MASK, SCR_MASK};
    localparam logic [N_PLAIN-1:0][XLEN-1:0] PL_RESET = {CTRL_RESET, {XLEN{1'b0}}};

    csr_dec_t        dec;
    logic            rd_req;
    logic            wr_req;
    logic [N_PLAIN-1:0]           sel_pl;
    logic [N_PLAIN-1:0][XLEN-1:0] pl_q;
    logic [N_PLAIN-1:0]           pl_wr;
    logic            sel_cnt;
    logic            sel_cnt_ro;
    logic            sel_id;
    logic            implemented;
    logic            read_only;
    logic [XLEN-1:0] old_val;
    logic [XLEN-1:0] operand;
    logic [XLEN-1:0] new_val;
    logic            act;
    logic            bad;
    logic            rd_go;
    logic            wr_go;
    logic            cnt_wr;
    logic [XLEN-1:0] cnt_q;

    csr_decode u_dec (
        .instr  (instr),
        .dec    (dec),
        .rd_req (rd_req),
        .wr_req (wr_req)
    );

    // Plain masked registers, one instance per table entry.
    for (genvar i = 0; i < N_PLAIN; i++) begin : g_plain
        assign sel_pl[i] = (dec.addr == PL_ADDR[i]);
        assign pl_wr[i]  = wr_go && sel_pl[i];
        csr_plain_reg #(
            .XLEN  (XLEN),
            .MASK  (PL_MASK[i]),
            .RESET (PL_RESET[i])
        ) u_reg (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (pl_wr[i]),
            .wr_val (new_val),
            .q      (pl_q[i])
        );
    end

    csr_retire_counter #(.XLEN(XLEN)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .retire (retire),
        .wr_en  (cnt_wr),
        .wr_val (new_val),
        .cnt    (cnt_q)
    );

    // Address match for the special registers and access class.
    always_comb begin
        sel_cnt     = (dec.addr == A_CNT);
        sel_cnt_ro  = (dec.addr == A_CNT_RO);
        sel_id      = (dec.addr == A_IDENT);
        implemented = (|sel_pl) || sel_cnt || sel_cnt_ro || sel_id;
        read_only   = sel_cnt_ro || sel_id;
    end

    // Select the current value of the addressed CSR (counter before increment).
    always_comb begin
        old_val = '0;
        for (int i = 0; i < N_PLAIN; i++) begin
            if (sel_pl[i]) old_val = old_val | pl_q[i];
        end
        if (sel_cnt || sel_cnt_ro) old_val = old_val | cnt_q;
        if (sel_id) old_val = old_val | IDENT_VALUE;
    end

    // Form the operand and the unmasked value to write.
    always_comb begin
        operand = dec.is_imm ? {{(XLEN-5){1'b0}}, dec.src} : rs1_val;
        case (dec.kind)
            K_SET:   new_val = old_val | operand;
            K_CLR:   new_val = old_val & ~operand;
            default: new_val = operand;
        endcase
    end

    // Decide legality and which side effects actually happen.
    always_comb begin
        act    = valid && dec.is_csr;
        bad    = act && (!implemented || (wr_req && read_only));
        rd_go  = act && !bad && rd_req;
        wr_go  = act && !bad && wr_req;
        cnt_wr = wr_go && sel_cnt;
    end

    // Register all results for the writeback stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_we       <= 1'b0;
            rd_addr     <= 5'd0;
            rd_data     <= '0;
            illegal     <= 1'b0;
            csr_rd_fire <= 1'b0;
            csr_wr_fire <= 1'b0;
        end else begin
            rd_we       <= rd_go && (dec.rd != 5'd0);
            rd_addr     <= rd_go ? dec.rd : 5'd0;
            rd_data     <= rd_go ? old_val : '0;
            illegal     <= bad;
            csr_rd_fire <= rd_go;
            csr_wr_fire <= wr_go;
        end
    end

endmodule

// File: rtl/csr_exec_checker.sv
// Assertion checker for csr_exec_unit, attached by bind.
// Observes ports plus the counter and its write path.
module csr_exec_checker
    import csr_exec_pkg::*;
#(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            valid,
    input logic [6:0]      opc,
    input logic [1:0]      kind,
    input logic [4:0]      src,
    input logic            retire,
    input logic            rd_we,
    input logic [4:0]      rd_addr,
    input logic            illegal,
    input logic            rd_fire,
    input logic            wr_fire,
    input logic [XLEN-1:0] cnt,
    input logic            cnt_wr,
    input logic [XLEN-1:0] cnt_wval
);

    logic acc_d;

    // Remember whether the previous cycle presented a CSR access.
    always_ff @(posedge clk) begin
        if (!rst_n) acc_d <= 1'b0;
        else        acc_d <= valid && (opc == OPC_SYSTEM) && (kind != 2'b00);
    end

    AST_ACTIVITY_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_fire || wr_fire || illegal) |-> acc_d); // R1
    AST_WB_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_we |-> rd_fire); // R2
    AST_SUPPRESS_ZERO_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && opc == OPC_SYSTEM && (kind == 2'b10 || kind == 2'b11) && src == 5'd0) |=> !wr_fire); // R4
    AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!rd_we && !rd_fire && !wr_fire)); // R7
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!retire && !cnt_wr) |=> $stable(cnt)); // R8
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (retire && !cnt_wr) |=> (cnt == $past(cnt) + 1'b1)); // R8
    AST_CNT_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (cnt == $past(cnt_wval))); // R9
    AST_NO_X0_WB: assert property (@(posedge clk) disable iff (!rst_n)
        rd_we |-> (rd_addr != 5'd0)); // R10

endmodule

bind csr_exec_unit csr_exec_checker #(.XLEN(XLEN)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .valid    (valid),
    .opc      (instr[6:0]),
    .kind     (instr[13:12]),
    .src      (instr[19:15]),
    .retire   (retire),
    .rd_we    (rd_we),
    .rd_addr  (rd_addr),
    .illegal  (illegal),
    .rd_fire  (csr_rd_fire),
    .wr_fire  (csr_wr_fire),
    .cnt      (cnt_q),
    .cnt_wr   (cnt_wr),
    .cnt_wval (new_val)
);

// File: tb/tb_csr_exec_unit.sv
module tb_csr_exec_unit;

    localparam int XLEN = 32;
    localparam logic [11:0] SCR = 12'h7C0, CTL = 12'h7C1, CNT = 12'hB02,
                            CRO = 12'hC02, IDW = 12'hFC0, BAD = 12'h123;
    localparam logic [31:0] IDV = 32'h1234_0001;

    typedef struct packed {
        logic [23:0] req;
        logic [2:0]  f3;
        logic [4:0]  rd;
        logic [4:0]  src;
        logic [11:0] addr;
        logic [31:0] rs1v;
        logic        we;
        logic [31:0] data;
        logic        ill;
        logic        rdf;
        logic        wrf;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VEC [NV] = '{
        '{"R2",  3'd1, 5'd1,  5'd2,  SCR, 32'hA5A5_5A5A, 1'b1, 32'h0,         1'b0, 1'b1, 1'b1},
        '{"R4",  3'd2, 5'd3,  5'd0,  SCR, 32'hFFFF_FFFF, 1'b1, 32'hA5A5_5A5A, 1'b0, 1'b1, 1'b0},
        '{"R3",  3'd3, 5'd4,  5'd5,  SCR, 32'h0000_FFFF, 1'b1, 32'hA5A5_5A5A, 1'b0, 1'b1, 1'b1},
        '{"R4",  3'd2, 5'd5,  5'd6,  SCR, 32'h0,         1'b1, 32'hA5A5_0000, 1'b0, 1'b1, 1'b1},
        '{"R2",  3'd1, 5'd0,  5'd7,  SCR, 32'h1234_5678, 1'b0, 32'h0,         1'b0, 1'b0, 1'b1},
        '{"R4",  3'd6, 5'd8,  5'd0,  SCR, 32'hFFFF_FFFF, 1'b1, 32'h1234_5678, 1'b0, 1'b1, 1'b0},
        '{"R5",  3'd6, 5'd8,  5'd31, SCR, 32'h0,         1'b1, 32'h1234_5678, 1'b0, 1'b1, 1'b1},
        '{"R5",  3'd7, 5'd9,  5'd15, SCR, 32'hFFFF_FFFF, 1'b1, 32'h1234_567F, 1'b0, 1'b1, 1'b1},
        '{"R5",  3'd5, 5'd10, 5'd21, SCR, 32'hFFFF_FFFF, 1'b1, 32'h1234_5670, 1'b0, 1'b1, 1'b1},
        '{"R2",  3'd5, 5'd0,  5'd3,  SCR, 32'h0,         1'b0, 32'h0,         1'b0, 1'b0, 1'b1},
        '{"R3",  3'd2, 5'd11, 5'd1,  CTL, 32'hFFFF_FFFF, 1'b1, 32'h0000_5000, 1'b0, 1'b1, 1'b1},
        '{"R3",  3'd1, 5'd12, 5'd1,  CTL, 32'h0,         1'b1, 32'h0000_5F0F, 1'b0, 1'b1, 1'b1},
        '{"R3",  3'd7, 5'd13, 5'd0,  CTL, 32'h0,         1'b1, 32'h0000_5000, 1'b0, 1'b1, 1'b0},
        '{"R6",  3'd2, 5'd14, 5'd0,  IDW, 32'hFFFF_FFFF, 1'b1, IDV,           1'b0, 1'b1, 1'b0},
        '{"R6",  3'd2, 5'd14, 5'd1,  IDW, 32'h0,         1'b0, 32'h0,         1'b1, 1'b0, 1'b0},
        '{"R6",  3'd5, 5'd0,  5'd0,  IDW, 32'h0,         1'b0, 32'h0,         1'b1, 1'b0, 1'b0},
        '{"R7",  3'd1, 5'd15, 5'd1,  BAD, 32'h55,        1'b0, 32'h0,         1'b1, 1'b0, 1'b0},
        '{"R7",  3'd2, 5'd15, 5'd0,  BAD, 32'h0,         1'b0, 32'h0,         1'b1, 1'b0, 1'b0},
        '{"R6",  3'd7, 5'd16, 5'd0,  CRO, 32'h0,         1'b1, 32'h0,         1'b0, 1'b1, 1'b0},
        '{"R10", 3'd2, 5'd0,  5'd0,  SCR, 32'h0,         1'b0, 32'h3,         1'b0, 1'b1, 1'b0},
        '{"R2",  3'd2, 5'd17, 5'd0,  SCR, 32'h0,         1'b1, 32'h3,         1'b0, 1'b1, 1'b0},
        '{"R1",  3'd0, 5'd0,  5'd0,  12'h0, 32'h0,       1'b0, 32'h0,         1'b0, 1'b0, 1'b0}
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            valid = 1'b0;
    logic [31:0]     instr = '0;
    logic [XLEN-1:0] rs1_val = '0;
    logic            retire = 1'b0;
    logic            rd_we;
    logic [4:0]      rd_addr;
    logic [XLEN-1:0] rd_data;
    logic            illegal;
    logic            csr_rd_fire;
    logic            csr_wr_fire;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    csr_exec_unit dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .valid       (valid),
        .instr       (instr),
        .rs1_val     (rs1_val),
        .retire      (retire),
        .rd_we       (rd_we),
        .rd_addr     (rd_addr),
        .rd_data     (rd_data),
        .illegal     (illegal),
        .csr_rd_fire (csr_rd_fire),
        .csr_wr_fire (csr_wr_fire)
    );

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req, input logic we, input logic [31:0] data,
                             input logic ill, input logic rdf, input logic wrf);
        check(req, "rd_we", 32'(rd_we), 32'(we));
        check(req, "rd_data", rd_data, data);
        check(req, "illegal", 32'(illegal), 32'(ill));
        check(req, "rd_fire", 32'(csr_rd_fire), 32'(rdf));
        check(req, "wr_fire", 32'(csr_wr_fire), 32'(wrf));
    endtask

    // Present one access at a negedge, let it be captured, return at the next negedge.
    task automatic run_op(input logic [31:0] word, input logic [31:0] v, input logic ret);
        instr   = word;
        rs1_val = v;
        retire  = ret;
        valid   = 1'b1;
        @(posedge clk);
        @(negedge clk);
        valid  = 1'b0;
        retire = 1'b0;
    endtask

    function automatic logic [31:0] mk(input logic [2:0] f3, input logic [4:0] rd,
                                       input logic [4:0] src, input logic [11:0] a);
        return {a, src, f3, rd, 7'b1110011};
    endfunction

    task automatic idle(input int n, input logic ret);
        retire = ret;
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
        retire = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            checks++;
            fails++;
            $display("FAIL R10 watchdog actual=%0d expected<=20000", cycles);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state of all outputs
        check_all("R10", 1'b0, 32'h0, 1'b0, 1'b0, 1'b0);
        check("R10", "rd_addr", 32'(rd_addr), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int k = 0; k < NV; k++) begin
            run_op(mk(VEC[k].f3, VEC[k].rd, VEC[k].src, VEC[k].addr), VEC[k].rs1v, 1'b0);
            check_all($sformatf("%s", VEC[k].req), VEC[k].we, VEC[k].data, VEC[k].ill, VEC[k].rdf, VEC[k].wrf);
            if (VEC[k].we) check($sformatf("%s", VEC[k].req), "rd_addr", 32'(rd_addr), 32'(VEC[k].rd));
        end

        // R8: five retires, then a read sees the pre-increment count
        idle(5, 1'b1);
        run_op(mk(3'd2, 5'd1, 5'd0, CNT), 32'h0, 1'b1);
        check("R8", "count read", rd_data, 32'd5);
        // R9: write in a retire cycle replaces the increment
        run_op(mk(3'd1, 5'd2, 5'd3, CNT), 32'd100, 1'b1);
        check("R9", "old count", rd_data, 32'd6);
        run_op(mk(3'd2, 5'd3, 5'd0, CRO), 32'h0, 1'b0);
        check("R9", "written count", rd_data, 32'd100);
        // R8: wrap from all ones
        run_op(mk(3'd1, 5'd0, 5'd3, CNT), 32'hFFFF_FFFF, 1'b0);
        idle(1, 1'b1);
        run_op(mk(3'd2, 5'd4, 5'd0, CNT), 32'h0, 1'b0);
        check("R8", "wrapped count", rd_data, 32'h0);
        // R6: write to the read-only view is illegal and leaves the counter
        run_op(mk(3'd2, 5'd4, 5'd1, CRO), 32'h1, 1'b0);
        check("R6", "illegal", 32'(illegal), 32'h1);
        run_op(mk(3'd2, 5'd4, 5'd0, CNT), 32'h0, 1'b0);
        check("R6", "count kept", rd_data, 32'h0);
        // R1: a non-SYSTEM opcode with a CSR-like funct3 does nothing
        run_op({SCR, 5'd1, 3'd1, 5'd1, 7'b0110011}, 32'hDEAD_BEEF, 1'b0);
        check_all("R1", 1'b0, 32'h0, 1'b0, 1'b0, 1'b0);
        run_op(mk(3'd2, 5'd5, 5'd0, SCR), 32'h0, 1'b0);
        check("R1", "scratch kept", rd_data, 32'h3);
        // R1: access word without valid does nothing
        instr = mk(3'd1, 5'd6, 5'd1, SCR);
        rs1_val = 32'h77;
        @(posedge clk);
        @(negedge clk);
        check_all("R1", 1'b0, 32'h0, 1'b0, 1'b0, 1'b0);
        // R10: reset mid-run restores register values
        run_op(mk(3'd1, 5'd0, 5'd1, SCR), 32'h99, 1'b0);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check_all("R10", 1'b0, 32'h0, 1'b0, 1'b0, 1'b0);
        rst_n = 1'b1;
        run_op(mk(3'd2, 5'd7, 5'd0, SCR), 32'h0, 1'b0);
        check("R10", "scratch after reset", rd_data, 32'h0);
        run_op(mk(3'd2, 5'd7, 5'd0, CTL), 32'h0, 1'b0);
        check("R10", "control after reset", rd_data, 32'h0000_5000);

        finish_run();
    end

endmodule